// File: doc/BRIEF.md
# DMA Channel Bus-Ownership Arbiter

This block decides, clock by clock, whether one DMA channel or the CPU owns a shared bus. Software programs a unit count and a channel control word through a small register port. It then sets the channel enable. The arbiter hands the bus to the DMA and counts the completion strobes that the transfer engine returns. In cycle-steal mode the bus goes back to the CPU after every unit. In burst mode the DMA keeps the bus until the count runs out.

A rising edge on the non-maskable interrupt input aborts the channel at once and returns the bus to the CPU. It also sets a sticky flag, even when the channel is idle. While that flag is set the channel cannot be started. The block also keeps a view of three interrupt sources: an edge request, an active-low level line and a peripheral flag. It shows which of them the CPU could service now, which is only when the CPU owns the bus.

The register port checks access widths. It refuses to change the resource-select field of a running channel.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, grant_cpu is 1, grant_dma, ch_busy, nmi_flag, xfer_end and addr_err are 0, irq_pend is 0, and the count and status registers read 0.
- R2: In cycle-steal mode (control bit 1 = 0), a unit strobe that is not the last moves the bus to the CPU at the next clock. The CPU then holds the bus for exactly CS_GAP clocks (default 2, at least 1) before the DMA takes it again.
- R3: In burst mode (control bit 1 = 1), grant_dma stays 1 on every clock from the start until the last unit, including the clocks between strobes.
- R4: The strobe that brings the count from 1 to 0 leaves, one clock later, the count at 0, ch_busy at 0, xfer_end at 1 and grant_cpu at 1.
- R5: A rising edge on nmi_in during a transfer gives, one clock later, grant_cpu 1, ch_busy 0 and nmi_flag 1. The count keeps the units that are still left, and a strobe in that same clock is not counted.
- R6: A rising edge on nmi_in while the channel is idle sets nmi_flag.
- R7: While nmi_flag is 1, writing the enable bit (control bit 0) to 1 does not start the channel. Writing 0 to status bit 1 clears the flag, and writing 1 to it has no effect. Enabling with a count of 0 also does not start the channel.
- R8: The resource-select field is control bits [7:4]. A control write that would change it while ch_busy is 1 is dropped completely. A write while idle, or one that leaves the field unchanged, is accepted.
- R9: Register addresses are 0 = status, 1 = control, 2 = count. Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = illegal. A byte access to the count register, or any size-3 access, is ignored and sets addr_err (status bit 2). Writing 0 to status bit 2 clears it. Byte writes to status or control are accepted without error, and a byte control write leaves bit 8 alone.
- R10: irq_serv shows the pending sources only while grant_cpu is 1, and is 0 whenever the DMA owns the bus. Bit order is [0] edge, [1] level, [2] peripheral.
- R11: An edge request stays pending until cpu_ack is seen while the CPU owns the bus. The level request is pending while irq_level_n is low. The peripheral request is pending while periph_irq is high. A request withdrawn during a burst is not serviceable when the bus comes back.
- R12: xfer_end is control bit 8. A 16-bit or 32-bit control write with bit 8 at 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the clock after reg_rd |
| xfer_done | input | 1 | Unit-complete strobe from the transfer engine |
| nmi_in | input | 1 | Non-maskable interrupt, rising edge acts |
| irq_edge_in | input | 1 | Edge-detected interrupt request line |
| irq_level_n | input | 1 | Level interrupt line, active low |
| periph_irq | input | 1 | Peripheral interrupt flag |
| cpu_ack | input | 1 | CPU starts handling the edge request |
| grant_dma | output | 1 | DMA owns the bus |
| grant_cpu | output | 1 | CPU owns the bus |
| ch_busy | output | 1 | Channel enable / busy |
| nmi_flag | output | 1 | Sticky NMI flag |
| xfer_end | output | 1 | Transfer-end flag |
| addr_err | output | 1 | Illegal-width access flag |
| irq_pend | output | 3 | Pending interrupt sources |
| irq_serv | output | 3 | Pending sources serviceable now |

## Verification
The assertions assume that the transfer engine raises xfer_done only while it holds the bus, and that cpu_ack comes only while the CPU owns the bus. The bench keeps to both rules: it pulses xfer_done only after it has seen grant_dma, and it acknowledges only after the bus has come back. The assertions also assume that nmi_in is a clean, synchronous signal. The stimulus changes nmi_in and the other inputs only on falling clock edges and holds each pulse for a full clock.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_DMA  = 2'd1,
    ARB_GAP  = 2'd2
  } arb_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  localparam int unsigned REG_STAT = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_CNT  = 2;

  localparam int unsigned IRQ_N = 3;
endpackage

// File: rtl/dmarb_ctrl.sv
module dmarb_ctrl
  import dmarb_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CS_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch_en,
  input  logic             burst,
  input  logic [CNT_W-1:0] count_q,
  input  logic             xfer_done,
  input  logic             nmi_in,
  output logic             nmi_evt,
  output logic             unit_dec,
  output logic             grant_dma,
  output logic             grant_cpu
);
  localparam int unsigned GAP_W = $clog2(CS_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

  arb_state_t       state_q, state_n;
  logic [GAP_W-1:0] gap_q;
  logic             nmi_prev;
  logic             last_unit;

  assign nmi_evt   = nmi_in & ~nmi_prev;
  assign unit_dec  = (state_q == ARB_DMA) & xfer_done & ~nmi_evt & ch_en;
  assign last_unit = (count_q == CNT_W'(1));

  always_comb begin
    state_n = state_q;
    case (state_q)
      ARB_IDLE: if (ch_en && !nmi_evt) state_n = ARB_DMA;
      ARB_DMA: begin
        if (nmi_evt || !ch_en)  state_n = ARB_IDLE;
        else if (unit_dec) begin
          if (last_unit)        state_n = ARB_IDLE;
          else if (!burst)      state_n = ARB_GAP;
        end
      end
      ARB_GAP: begin
        if (nmi_evt || !ch_en)  state_n = ARB_IDLE;
        else if (gap_q == GAP_LAST) state_n = ARB_DMA;
      end
      default: state_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ARB_IDLE;
      gap_q     <= '0;
      nmi_prev  <= 1'b0;
      grant_dma <= 1'b0;
      grant_cpu <= 1'b1;
    end else begin
      state_q   <= state_n;
      nmi_prev  <= nmi_in;
      gap_q     <= (state_q == ARB_GAP) ? gap_q + 1'b1 : '0;
      grant_dma <= (state_n == ARB_DMA);
      grant_cpu <= (state_n != ARB_DMA);
    end
  end

  // R2
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_dma && !burst && xfer_done && !nmi_evt) |=> (grant_cpu && !grant_dma));

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_dma && burst && ch_en && !xfer_done && !nmi_evt) |=> grant_dma);

  // R5
  nmi_abort_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_evt |=> (grant_cpu && !grant_dma));
endmodule

// File: rtl/dmarb_regs.sv
module dmarb_regs
  import dmarb_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              nmi_evt,
  input  logic              unit_dec,
  output logic              ch_en_q,
  output logic              burst_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              nmi_flag_q,
  output logic              te_q,
  output logic              addr_err_q
);
  localparam int unsigned RS_LO  = 4;
  localparam int unsigned RS_HI  = RS_LO + RSEL_W - 1;
  localparam int unsigned TE_BIT = RS_HI + 1;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);

  logic [RSEL_W-1:0] rsel_q;
  logic [RSEL_W-1:0] rsel_w;
  logic bad_acc, stat_wr_ok, ctrl_wr_ok, cnt_wr_ok, end_hit, rsel_clash;
  logic [DATA_W-1:0] rd_mux;

  assign rsel_w     = reg_wdata[RS_HI:RS_LO];
  assign bad_acc    = (reg_wr | reg_rd) &
                      ((reg_size == SZ_BAD) || (reg_addr == A_CNT && reg_size == SZ_BYTE));
  assign rsel_clash = ch_en_q && (rsel_w != rsel_q);
  assign stat_wr_ok = reg_wr && reg_addr == A_STAT && reg_size != SZ_BAD;
  assign ctrl_wr_ok = reg_wr && reg_addr == A_CTRL && reg_size != SZ_BAD && !rsel_clash;
  assign cnt_wr_ok  = reg_wr && reg_addr == A_CNT && !bad_acc && !ch_en_q;
  assign end_hit    = unit_dec && (count_q == CNT_W'(1));

  always_comb begin
    rd_mux = '0;
    if (!bad_acc) begin
      case (reg_addr)
        A_STAT: begin
          rd_mux[1] = nmi_flag_q;
          rd_mux[2] = addr_err_q;
        end
        A_CTRL: begin
          rd_mux[0]           = ch_en_q;
          rd_mux[1]           = burst_q;
          rd_mux[RS_HI:RS_LO] = rsel_q;
          rd_mux[TE_BIT]      = te_q;
        end
        A_CNT:   rd_mux[CNT_W-1:0] = count_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en_q    <= 1'b0;
      burst_q    <= 1'b0;
      rsel_q     <= '0;
      te_q       <= 1'b0;
      count_q    <= '0;
      nmi_flag_q <= 1'b0;
      addr_err_q <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;

      if (nmi_evt)                          nmi_flag_q <= 1'b1;
      else if (stat_wr_ok && !reg_wdata[1]) nmi_flag_q <= 1'b0;

      if (bad_acc)                          addr_err_q <= 1'b1;
      else if (stat_wr_ok && !reg_wdata[2]) addr_err_q <= 1'b0;

      if (nmi_evt || end_hit)  ch_en_q <= 1'b0;
      else if (ctrl_wr_ok)
        ch_en_q <= reg_wdata[0] && (ch_en_q || (!nmi_flag_q && count_q != '0));

      if (ctrl_wr_ok) begin
        burst_q <= reg_wdata[1];
        rsel_q  <= rsel_w;
      end

      if (end_hit) te_q <= 1'b1;
      else if (ctrl_wr_ok && reg_size != SZ_BYTE && !reg_wdata[TE_BIT]) te_q <= 1'b0;

      if (unit_dec && !nmi_evt) count_q <= count_q - 1'b1;
      else if (cnt_wr_ok)       count_q <= reg_wdata[CNT_W-1:0];
    end
  end

  // R4
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    end_hit |=> (count_q == '0 && !ch_en_q && te_q));

  // R7
  nmi_block_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_flag_q |-> !ch_en_q);

  // R6
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_evt |=> nmi_flag_q);

  // R8
  rsel_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_en_q && reg_wr && reg_addr == A_CTRL && rsel_w != rsel_q) |=> $stable(rsel_q));

  // R9
  width_err_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CNT && reg_size == SZ_BYTE && !unit_dec)
      |=> (addr_err_q && $stable(count_q)));
endmodule

// File: rtl/dmarb_irq.sv
module dmarb_irq
  import dmarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_edge_in,
  input  logic             irq_level_n,
  input  logic             periph_irq,
  input  logic             cpu_ack,
  input  logic             grant_cpu,
  output logic [IRQ_N-1:0] irq_pend,
  output logic [IRQ_N-1:0] irq_serv
);
  logic edge_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_prev <= 1'b0;
      irq_pend  <= '0;
    end else begin
      edge_prev <= irq_edge_in;
      if (irq_edge_in && !edge_prev)   irq_pend[0] <= 1'b1;
      else if (cpu_ack && grant_cpu)   irq_pend[0] <= 1'b0;
      irq_pend[1] <= ~irq_level_n;
      irq_pend[2] <= periph_irq;
    end
  end

  assign irq_serv = irq_pend & {IRQ_N{grant_cpu}};

  // R11
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pend[0] && !(cpu_ack && grant_cpu)) |=> irq_pend[0]);

  // R10
  serv_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_cpu |-> (irq_serv == '0));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dmarb_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RSEL_W = 4,
  parameter int unsigned CS_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done,
  input  logic              nmi_in,
  input  logic              irq_edge_in,
  input  logic              irq_level_n,
  input  logic              periph_irq,
  input  logic              cpu_ack,
  output logic              grant_dma,
  output logic              grant_cpu,
  output logic              ch_busy,
  output logic              nmi_flag,
  output logic              xfer_end,
  output logic              addr_err,
  output logic [2:0]        irq_pend,
  output logic [2:0]        irq_serv
);
  logic             nmi_evt, unit_dec, burst;
  logic [CNT_W-1:0] count_q;

  dmarb_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RSEL_W(RSEL_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_evt(nmi_evt), .unit_dec(unit_dec),
    .ch_en_q(ch_busy), .burst_q(burst), .count_q(count_q),
    .nmi_flag_q(nmi_flag), .te_q(xfer_end), .addr_err_q(addr_err)
  );

  dmarb_ctrl #(
    .CNT_W(CNT_W), .CS_GAP(CS_GAP)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .ch_en(ch_busy), .burst(burst), .count_q(count_q),
    .xfer_done(xfer_done), .nmi_in(nmi_in),
    .nmi_evt(nmi_evt), .unit_dec(unit_dec),
    .grant_dma(grant_dma), .grant_cpu(grant_cpu)
  );

  dmarb_irq irq_i (
    .clk(clk), .rst(rst),
    .irq_edge_in(irq_edge_in), .irq_level_n(irq_level_n),
    .periph_irq(periph_irq), .cpu_ack(cpu_ack), .grant_cpu(grant_cpu),
    .irq_pend(irq_pend), .irq_serv(irq_serv)
  );
endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb_top;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0, reg_size = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        xfer_done = 0, nmi_in = 0, irq_edge_in = 0, irq_level_n = 1;
  logic        periph_irq = 0, cpu_ack = 0;
  logic        grant_dma, grant_cpu, ch_busy, nmi_flag, xfer_end, addr_err;
  logic [2:0]  irq_pend, irq_serv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dma_bus_arbiter #(.CS_GAP(GAP)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done(xfer_done), .nmi_in(nmi_in), .irq_edge_in(irq_edge_in),
    .irq_level_n(irq_level_n), .periph_irq(periph_irq), .cpu_ack(cpu_ack),
    .grant_dma(grant_dma), .grant_cpu(grant_cpu), .ch_busy(ch_busy),
    .nmi_flag(nmi_flag), .xfer_end(xfer_end), .addr_err(addr_err),
    .irq_pend(irq_pend), .irq_serv(irq_serv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a; reg_size = 2'd2;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_dma();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (grant_dma) break;
    end
  endtask

  task automatic unit();
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 grant_cpu", grant_cpu, 1);
    check("R1 grant_dma", grant_dma, 0);
    check("R1 flags", {ch_busy, nmi_flag, xfer_end, addr_err}, 0);
    check("R1 irq_pend", irq_pend, 0);
    rd(2, v); check("R1 count", v, 0);
    rd(0, v); check("R1 status", v, 0);
  endtask

  task automatic t_cycle_steal();
    int n;
    logic [31:0] v;
    wr(2, 2, 3);
    wr(1, 2, 32'h01);
    wait_dma();
    check("R2 dma owns", grant_dma, 1);
    for (int u = 0; u < 2; u++) begin
      unit();
      check("R2 release", grant_cpu, 1);
      n = 0;
      while (grant_cpu && n < 20) begin n++; @(negedge clk); end
      check("R2 gap length", n, GAP);
    end
    unit();
    check("R4 cpu after end", grant_cpu, 1);
    check("R4 busy/end", {ch_busy, xfer_end}, 2'b01);
    rd(2, v); check("R4 count", v, 0);
  endtask

  task automatic t_burst();
    bit held;
    wr(1, 2, 32'h00);
    check("R12 end cleared", xfer_end, 0);
    wr(2, 2, 4);
    wr(1, 2, 32'h03);
    wait_dma();
    held = 1;
    for (int u = 0; u < 3; u++) begin
      unit();
      if (!grant_dma) held = 0;
      repeat (2) begin @(negedge clk); if (!grant_dma || grant_cpu) held = 0; end
    end
    check("R3 held", held, 1);
    unit();
    check("R4 burst end", {grant_cpu, ch_busy, xfer_end}, 3'b101);
  endtask

  task automatic t_nmi_abort();
    logic [31:0] v;
    wr(1, 2, 32'h00);
    wr(2, 2, 5);
    wr(1, 2, 32'h03);
    wait_dma();
    unit();
    check("R3 still dma", grant_dma, 1);
    nmi_in = 1; xfer_done = 1;
    @(negedge clk);
    nmi_in = 0; xfer_done = 0;
    check("R5 abort", {grant_cpu, ch_busy, nmi_flag}, 3'b101);
    rd(2, v); check("R5 count kept", v, 4);
  endtask

  task automatic t_nmi_block();
    wr(1, 2, 32'h03);
    repeat (3) @(negedge clk);
    check("R7 no start", {grant_dma, ch_busy}, 0);
    wr(0, 2, 32'h6);
    check("R7 write 1 keeps", nmi_flag, 1);
    wr(0, 2, 32'h0);
    check("R7 cleared", nmi_flag, 0);
    wr(1, 2, 32'h03);
    wait_dma();
    check("R7 restart", grant_dma, 1);
    wr(1, 2, 32'h02);
    @(negedge clk);
    check("R7 stopped", {grant_cpu, ch_busy}, 2'b10);
  endtask

  task automatic t_nmi_idle();
    nmi_in = 1;
    @(negedge clk);
    nmi_in = 0;
    check("R6 idle flag", nmi_flag, 1);
    check("R6 cpu keeps bus", grant_cpu, 1);
    wr(0, 2, 32'h0);
    check("R6 cleared", nmi_flag, 0);
  endtask

  task automatic t_rsel();
    logic [31:0] v;
    wr(1, 2, 32'h50);
    rd(1, v); check("R8 idle write", v, 32'h50);
    wr(2, 2, 2);
    wr(1, 2, 32'h53);
    wr(1, 2, 32'h93);
    rd(1, v); check("R8 rejected", v, 32'h53);
    check("R8 still busy", ch_busy, 1);
    wr(1, 2, 32'h50);
    check("R8 same rsel ok", ch_busy, 0);
  endtask

  task automatic t_width();
    logic [31:0] v;
    wr(2, 0, 7);
    check("R9 byte err", addr_err, 1);
    rd(2, v); check("R9 byte ignored", v, 2);
    wr(0, 2, 0);
    check("R9 err cleared", addr_err, 0);
    wr(2, 3, 8);
    check("R9 size3 err", addr_err, 1);
    rd(2, v); check("R9 size3 ignored", v, 2);
    wr(0, 2, 0);
    wr(2, 1, 9);
    rd(2, v); check("R9 half ok", v, 9);
    wr(1, 0, 32'h70);
    rd(1, v); check("R9 byte ctrl ok", v, 32'h70);
    check("R9 no err", addr_err, 0);
  endtask

  task automatic t_irq();
    wr(2, 1, 2);
    wr(1, 2, 32'h73);
    wait_dma();
    irq_edge_in = 1; irq_level_n = 0; periph_irq = 1;
    @(negedge clk);
    irq_edge_in = 0;
    @(negedge clk);
    check("R11 pend all", irq_pend, 3'b111);
    check("R10 none serv in burst", irq_serv, 3'b000);
    periph_irq = 0;
    repeat (2) @(negedge clk);
    unit();
    unit();
    check("R10 bus back", grant_cpu, 1);
    check("R11 serv after burst", irq_serv, 3'b011);
    cpu_ack = 1;
    @(negedge clk);
    cpu_ack = 0;
    check("R11 edge acked", irq_pend[0], 0);
    irq_level_n = 1;
    @(negedge clk);
    check("R11 level gone", irq_pend[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cycle_steal();
    t_burst();
    t_nmi_abort();
    t_nmi_block();
    t_nmi_idle();
    t_rsel();
    t_width();
    t_irq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule